// File: doc/BRIEF.md
# Firmware Segment Loader

This block writes the loadable segments of a firmware image into the two local memories of a small embedded controller. A host presents one segment descriptor at a time: type code, flags, physical load address, offset of the segment inside the image, file size, memory size and total image size. It then supplies the segment's file bytes on a byte stream. Segments flagged executable go to instruction memory. All other segments go to data memory.

Instruction code arrives as packed 24-bit words. The loader widens each one to a 32-bit slot by writing a zero byte after every third source byte. Data segments are copied byte for byte. The loader then writes zeros until the segment's memory size is reached. The word-based load address is turned into a byte address by keeping its low bits and multiplying by four.

Segments of any type other than the load type are passed over. A segment that claims bytes beyond the end of the image is refused. Both memory ports are byte-wide with a valid/ready handshake. A stalled port stalls the byte stream, so no data is lost.

Top module: `seg_loader`

## Requirements
- R1: A segment whose flags bit 0 is set is written only through the instruction port. Any other segment is written only through the data port. The remaining flag bits have no effect.
- R2: The first byte of a segment goes to byte address `paddr[PADDR_BITS-1:0] * 4`. Each following write goes to the next byte address, wrapping modulo the address space. Address bits at and above PADDR_BITS are ignored.
- R3: In an instruction segment, source byte i is copied in order, and a 0x00 byte is written after every source byte with i mod 3 == 2. A final group shorter than three bytes gets no pad. The memory size is ignored.
- R4: In a data segment, the file-size bytes are copied in order. Then memsz − filesz bytes of 0x00 follow, or none when memsz ≤ filesz.
- R5: A descriptor whose type field differs from LOAD_CODE (default 1) is accepted and ignored: no memory write, no stream byte consumed, and no seg_done or seg_err.
- R6: A load descriptor with offset + filesz > image_size, computed without overflow, is refused. Equality is accepted. A refused segment makes no write, consumes no byte, and raises seg_err for one cycle, the cycle after acceptance.
- R7: seg_done pulses for one cycle, the cycle after the last write handshake of the segment. For a segment with nothing to write, it pulses the cycle after acceptance. It never coincides with seg_err.
- R8: in_ready is high only when the byte on the stream is written in the same cycle. A port that holds ready low stalls the stream, and every stream byte is written exactly once.
- R9: desc_ready is high only while no segment is in progress. After reset, desc_ready is 1, and in_ready, both write enables, seg_done and seg_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_valid | input | 1 | Descriptor valid |
| desc_ready | output | 1 | Loader idle, descriptor taken |
| desc_type | input | TYPE_W | Segment type code |
| desc_flags | input | FLAG_W | Segment flags, bit 0 = executable |
| desc_paddr | input | PADDR_W | Word load address |
| desc_offset | input | LEN_W | Segment offset inside the image |
| desc_filesz | input | LEN_W | Bytes present in the image |
| desc_memsz | input | LEN_W | Bytes occupied in memory |
| image_size | input | LEN_W | Total image size in bytes |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte consumed |
| in_data | input | 8 | Stream byte |
| imem_we | output | 1 | Instruction memory write request |
| imem_addr | output | PADDR_BITS+2 | Instruction memory byte address |
| imem_data | output | 8 | Instruction memory write byte |
| imem_ready | input | 1 | Instruction memory accepts write |
| dmem_we | output | 1 | Data memory write request |
| dmem_addr | output | PADDR_BITS+2 | Data memory byte address |
| dmem_data | output | 8 | Data memory write byte |
| dmem_ready | input | 1 | Data memory accepts write |
| seg_done | output | 1 | Segment finished pulse |
| seg_err | output | 1 | Segment refused pulse |

## Verification
A descriptor is taken at the edge where desc_valid and desc_ready are both high. seg_err, or seg_done for an empty segment, is due exactly one cycle later. Every write happens at the edge where write enable and port ready are both high. seg_done follows the last such edge by one cycle. The bench samples every handshake a few nanoseconds after the falling edge and stamps it with a cycle counter. It then compares the stamp of each pulse against the stamp of the event that must precede it by exactly one cycle.

// File: rtl/seg_loader_pkg.sv
// Shared types of the segment loader.
// Assumes: nothing beyond IEEE 1800-2017.
package seg_loader_pkg;

    // Sequencer states: idle, copying stream bytes, writing a pad zero, writing the zero tail
    typedef enum logic [1:0] {
        LS_IDLE,
        LS_COPY,
        LS_PAD,
        LS_ZERO
    } ld_state_t;

    // What the screen decides for a presented descriptor
    typedef enum logic [1:0] {
        ACT_SKIP,
        ACT_REJECT,
        ACT_EMPTY,
        ACT_RUN
    } seg_act_t;

    // Source bytes per instruction before a pad byte is inserted
    localparam int unsigned GROUP_BYTES = 3;

endpackage

// File: rtl/seg_loader_screen.sv
// Descriptor screen: classifies a presented descriptor as skip, reject,
// empty or run, and computes the zero-tail length of a data segment.
// Assumes: purely combinational; the sum check is one bit wider than the
// size fields so that it cannot overflow.
module seg_loader_screen
    import seg_loader_pkg::*;
#(
    parameter int LEN_W     = 32,
    parameter int TYPE_W    = 4,
    parameter int LOAD_CODE = 1
) (
    input  logic [TYPE_W-1:0] desc_type,
    input  logic              is_exec,
    input  logic [LEN_W-1:0]  desc_offset,
    input  logic [LEN_W-1:0]  desc_filesz,
    input  logic [LEN_W-1:0]  desc_memsz,
    input  logic [LEN_W-1:0]  image_size,
    output seg_act_t          act,
    output logic [LEN_W-1:0]  tail_len
);

    logic [LEN_W:0] span;
    logic           overrun;

    // End of segment inside the image, and the bounds test against the image size
    always_comb begin
        span    = {1'b0, desc_offset} + {1'b0, desc_filesz};
        overrun = span > {1'b0, image_size};
    end

    // Zero tail applies only to data segments that are larger in memory than in the file
    always_comb begin
        if (!is_exec && (desc_memsz > desc_filesz)) begin
            tail_len = desc_memsz - desc_filesz;
        end else begin
            tail_len = '0;
        end
    end

    // Classification, ordered by priority: type first, then bounds, then size
    always_comb begin
        if (desc_type != TYPE_W'(LOAD_CODE)) begin
            act = ACT_SKIP;
        end else if (overrun) begin
            act = ACT_REJECT;
        end else if ((desc_filesz == '0) && (tail_len == '0)) begin
            act = ACT_EMPTY;
        end else begin
            act = ACT_RUN;
        end
    end

endmodule

// File: rtl/seg_loader_fsm.sv
// Load sequencer: takes one descriptor while idle, then walks the write
// address through the copy, pad and zero-tail phases. It issues the done
// or error pulse one cycle after the deciding handshake.
// Assumes: port_ready is the ready of the port chosen by exec_sel; a write
// completes on a cycle with wr_req and port_ready both high.
module seg_loader_fsm
    import seg_loader_pkg::*;
#(
    parameter int LEN_W  = 32,
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    input  seg_act_t          act,
    input  logic              is_exec,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LEN_W-1:0]  filesz,
    input  logic [LEN_W-1:0]  tail_len,
    input  logic              in_valid,
    input  logic              port_ready,
    output logic              desc_ready,
    output logic              in_ready,
    output logic              wr_req,
    output logic              wr_zero,
    output logic              exec_sel,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              seg_done,
    output logic              seg_err
);

    ld_state_t         state;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [LEN_W-1:0]  zrem_q;
    logic [1:0]        phase_q;
    logic              exec_q;
    logic              done_q;
    logic              err_q;
    logic              fire;
    logic              take;

    // Handshake and write request decode for the current state
    always_comb begin
        desc_ready = (state == LS_IDLE);
        take       = desc_ready && desc_valid;
        in_ready   = (state == LS_COPY) && port_ready;
        wr_req     = ((state == LS_COPY) && in_valid) ||
                     (state == LS_PAD) || (state == LS_ZERO);
        wr_zero    = (state != LS_COPY);
        fire       = wr_req && port_ready;
    end

    // State, counters and pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= LS_IDLE;
            addr_q  <= '0;
            rem_q   <= '0;
            zrem_q  <= '0;
            phase_q <= '0;
            exec_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state)
                LS_IDLE: begin
                    if (take) begin
                        exec_q  <= is_exec;
                        addr_q  <= base_addr;
                        rem_q   <= filesz;
                        zrem_q  <= tail_len;
                        phase_q <= '0;
                        unique case (act)
                            ACT_SKIP:   state <= LS_IDLE;
                            ACT_REJECT: err_q <= 1'b1;
                            ACT_EMPTY:  done_q <= 1'b1;
                            ACT_RUN:    state <= (filesz == '0) ? LS_ZERO : LS_COPY;
                        endcase
                    end
                end
                LS_COPY: begin
                    if (fire) begin
                        addr_q  <= addr_q + 1'b1;
                        rem_q   <= rem_q - 1'b1;
                        phase_q <= (phase_q == 2'(GROUP_BYTES - 1)) ? 2'd0 : phase_q + 2'd1;
                        if (exec_q && (phase_q == 2'(GROUP_BYTES - 1))) begin
                            state <= LS_PAD;
                        end else if (rem_q == LEN_W'(1)) begin
                            if (zrem_q != '0) begin
                                state <= LS_ZERO;
                            end else begin
                                done_q <= 1'b1;
                                state  <= LS_IDLE;
                            end
                        end
                    end
                end
                LS_PAD: begin
                    if (fire) begin
                        addr_q <= addr_q + 1'b1;
                        if (rem_q == '0) begin
                            done_q <= 1'b1;
                            state  <= LS_IDLE;
                        end else begin
                            state <= LS_COPY;
                        end
                    end
                end
                LS_ZERO: begin
                    if (fire) begin
                        addr_q <= addr_q + 1'b1;
                        zrem_q <= zrem_q - 1'b1;
                        if (zrem_q == LEN_W'(1)) begin
                            done_q <= 1'b1;
                            state  <= LS_IDLE;
                        end
                    end
                end
                default: state <= LS_IDLE;
            endcase
        end
    end

    // Registered outputs brought to the ports
    always_comb begin
        exec_sel = exec_q;
        wr_addr  = addr_q;
        seg_done = done_q;
        seg_err  = err_q;
    end

endmodule

// File: rtl/seg_loader_route.sv
// Port router: steers the single write request to the instruction or data
// port, picks the pass-through byte or a zero, and returns the chosen
// port's ready.
// Assumes: exec_sel is stable for a whole segment.
module seg_loader_route #(
    parameter int ADDR_W = 22
) (
    input  logic              wr_req,
    input  logic              wr_zero,
    input  logic              exec_sel,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        stream_data,
    input  logic              imem_ready,
    input  logic              dmem_ready,
    output logic              imem_we,
    output logic [ADDR_W-1:0] imem_addr,
    output logic [7:0]        imem_data,
    output logic              dmem_we,
    output logic [ADDR_W-1:0] dmem_addr,
    output logic [7:0]        dmem_data,
    output logic              port_ready
);

    localparam int NPORT = 2;

    logic [NPORT-1:0] we_v;
    logic [NPORT-1:0] rdy_v;
    logic [7:0]       wbyte;

    // Per-port enable: index 0 serves executable segments, index 1 the rest
    for (genvar g = 0; g < NPORT; g++) begin : g_port
        assign we_v[g] = wr_req && (exec_sel == (g == 0));
    end

    // Byte selection, fan-out to both ports and ready return
    always_comb begin
        rdy_v      = {dmem_ready, imem_ready};
        wbyte      = wr_zero ? 8'h00 : stream_data;
        imem_we    = we_v[0];
        dmem_we    = we_v[1];
        imem_addr  = wr_addr;
        dmem_addr  = wr_addr;
        imem_data  = wbyte;
        dmem_data  = wbyte;
        port_ready = exec_sel ? rdy_v[0] : rdy_v[1];
    end

endmodule

// File: rtl/seg_loader.sv
// Firmware segment loader top: screens each descriptor, then writes the
// segment into instruction memory (packed 3 bytes into 4) or data memory
// (with a zero tail).
// Assumes: bytes arrive in file order after the descriptor is taken; the
// memory ports are byte-wide with valid/ready.
module seg_loader
    import seg_loader_pkg::*;
#(
    parameter int PADDR_W    = 32,
    parameter int PADDR_BITS = 20,
    parameter int LEN_W      = 32,
    parameter int TYPE_W     = 4,
    parameter int FLAG_W     = 3,
    parameter int EXEC_BIT   = 0,
    parameter int LOAD_CODE  = 1,
    localparam int ADDR_W    = PADDR_BITS + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               desc_valid,
    output logic               desc_ready,
    input  logic [TYPE_W-1:0]  desc_type,
    input  logic [FLAG_W-1:0]  desc_flags,
    input  logic [PADDR_W-1:0] desc_paddr,
    input  logic [LEN_W-1:0]   desc_offset,
    input  logic [LEN_W-1:0]   desc_filesz,
    input  logic [LEN_W-1:0]   desc_memsz,
    input  logic [LEN_W-1:0]   image_size,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [7:0]         in_data,
    output logic               imem_we,
    output logic [ADDR_W-1:0]  imem_addr,
    output logic [7:0]         imem_data,
    input  logic               imem_ready,
    output logic               dmem_we,
    output logic [ADDR_W-1:0]  dmem_addr,
    output logic [7:0]         dmem_data,
    input  logic               dmem_ready,
    output logic               seg_done,
    output logic               seg_err
);

    seg_act_t          act;
    logic [LEN_W-1:0]  tail_len;
    logic              is_exec;
    logic [ADDR_W-1:0] base_addr;
    logic              wr_req;
    logic              wr_zero;
    logic              exec_sel;
    logic [ADDR_W-1:0] wr_addr;
    logic              port_ready;
    logic              unused_bits;

    // Word address to byte address, and the executable flag pick
    always_comb begin
        base_addr   = {desc_paddr[PADDR_BITS-1:0], 2'b00};
        is_exec     = desc_flags[EXEC_BIT];
        unused_bits = ^{desc_paddr, desc_flags};
    end

    seg_loader_screen #(
        .LEN_W     (LEN_W),
        .TYPE_W    (TYPE_W),
        .LOAD_CODE (LOAD_CODE)
    ) u_screen (
        .desc_type   (desc_type),
        .is_exec     (is_exec),
        .desc_offset (desc_offset),
        .desc_filesz (desc_filesz),
        .desc_memsz  (desc_memsz),
        .image_size  (image_size),
        .act         (act),
        .tail_len    (tail_len)
    );

    seg_loader_fsm #(
        .LEN_W  (LEN_W),
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_valid (desc_valid),
        .act        (act),
        .is_exec    (is_exec),
        .base_addr  (base_addr),
        .filesz     (desc_filesz),
        .tail_len   (tail_len),
        .in_valid   (in_valid),
        .port_ready (port_ready),
        .desc_ready (desc_ready),
        .in_ready   (in_ready),
        .wr_req     (wr_req),
        .wr_zero    (wr_zero),
        .exec_sel   (exec_sel),
        .wr_addr    (wr_addr),
        .seg_done   (seg_done),
        .seg_err    (seg_err)
    );

    seg_loader_route #(
        .ADDR_W (ADDR_W)
    ) u_route (
        .wr_req      (wr_req),
        .wr_zero     (wr_zero),
        .exec_sel    (exec_sel),
        .wr_addr     (wr_addr),
        .stream_data (in_data),
        .imem_ready  (imem_ready),
        .dmem_ready  (dmem_ready),
        .imem_we     (imem_we),
        .imem_addr   (imem_addr),
        .imem_data   (imem_data),
        .dmem_we     (dmem_we),
        .dmem_addr   (dmem_addr),
        .dmem_data   (dmem_data),
        .port_ready  (port_ready)
    );

endmodule

// File: rtl/seg_loader_chk.sv
// Protocol checker for the segment loader, attached by bind.
// Assumes: observes top-level ports only.
module seg_loader_chk #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              desc_valid,
    input logic              desc_ready,
    input logic              in_valid,
    input logic              in_ready,
    input logic [7:0]        in_data,
    input logic              imem_we,
    input logic [ADDR_W-1:0] imem_addr,
    input logic [7:0]        imem_data,
    input logic              imem_ready,
    input logic              dmem_we,
    input logic [ADDR_W-1:0] dmem_addr,
    input logic [7:0]        dmem_data,
    input logic              dmem_ready,
    input logic              seg_done,
    input logic              seg_err
);

    // R1
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({imem_we, dmem_we}));

    // R2
    iaddr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_we && imem_ready) |=> (!imem_we || (imem_addr == ADDR_W'($past(imem_addr) + 1'b1))));

    // R2
    daddr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_we && dmem_ready) |=> (!dmem_we || (dmem_addr == ADDR_W'($past(dmem_addr) + 1'b1))));

    // R3
    ibyte_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_we && (imem_data != 8'h00)) |-> (in_valid && (imem_data == in_data)));

    // R4
    dbyte_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_we && (dmem_data != 8'h00)) |-> (in_valid && (dmem_data == in_data)));

    // R6
    err_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_err |-> $past(desc_valid && desc_ready));

    // R7
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(seg_done && seg_err));

    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_done |-> $past((desc_valid && desc_ready) || (imem_we && imem_ready) ||
                           (dmem_we && dmem_ready)));

    // R8
    in_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> ((imem_we && imem_ready) || (dmem_we && dmem_ready)));

    // R9
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_we || dmem_we) |-> !desc_ready);

endmodule

bind seg_loader seg_loader_chk #(
    .ADDR_W (ADDR_W)
) u_seg_loader_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .imem_we    (imem_we),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .imem_ready (imem_ready),
    .dmem_we    (dmem_we),
    .dmem_addr  (dmem_addr),
    .dmem_data  (dmem_data),
    .dmem_ready (dmem_ready),
    .seg_done   (seg_done),
    .seg_err    (seg_err)
);

// File: tb/test_seg_loader.sv
// Bench: sweeps instruction and data segments over a small address space,
// with varied port stalls, and checks the memories, pulses and timing.
module test_seg_loader;

    localparam int PB  = 6;
    localparam int AW  = PB + 2;
    localparam int MEM = 1 << AW;
    localparam int IMG = 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          desc_valid = 1'b0;
    logic          desc_ready;
    logic [3:0]    desc_type = '0;
    logic [2:0]    desc_flags = '0;
    logic [31:0]   desc_paddr = '0;
    logic [31:0]   desc_offset = '0;
    logic [31:0]   desc_filesz = '0;
    logic [31:0]   desc_memsz = '0;
    logic [31:0]   image_size = 32'(IMG);
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_data = '0;
    logic          imem_we;
    logic [AW-1:0] imem_addr;
    logic [7:0]    imem_data;
    logic          imem_ready = 1'b1;
    logic          dmem_we;
    logic [AW-1:0] dmem_addr;
    logic [7:0]    dmem_data;
    logic          dmem_ready = 1'b1;
    logic          seg_done;
    logic          seg_err;

    seg_loader #(.PADDR_BITS(PB)) i_seg_loader (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_type(desc_type), .desc_flags(desc_flags), .desc_paddr(desc_paddr),
        .desc_offset(desc_offset), .desc_filesz(desc_filesz), .desc_memsz(desc_memsz),
        .image_size(image_size), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .imem_we(imem_we), .imem_addr(imem_addr), .imem_data(imem_data), .imem_ready(imem_ready),
        .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_data(dmem_data), .dmem_ready(dmem_ready),
        .seg_done(seg_done), .seg_err(seg_err)
    );

    always #5 clk = ~clk;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    int mode    = 0;
    int rcnt    = 0;
    logic [7:0] exp_i [MEM];
    logic [7:0] exp_d [MEM];
    logic [7:0] got_i [MEM];
    logic [7:0] got_d [MEM];
    int n_wi, n_wd, n_in, n_done, n_err, last_evt, done_cyc, err_cyc;

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 13 + i * 29) % 251 + 1);
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // port stall pattern, set at the falling edge
    always @(negedge clk) begin
        rcnt++;
        case (mode)
            1:       begin imem_ready = rcnt[0];        dmem_ready = ~rcnt[0]; end
            2:       begin imem_ready = (rcnt % 3) != 0; dmem_ready = (rcnt % 3) != 1; end
            default: begin imem_ready = 1'b1;           dmem_ready = 1'b1; end
        endcase
    end

    // handshake monitor, sampling what the next rising edge commits
    always @(negedge clk) begin
        #3;
        if (imem_we && imem_ready) begin got_i[imem_addr] = imem_data; n_wi++; last_evt = cyc; end
        if (dmem_we && dmem_ready) begin got_d[dmem_addr] = dmem_data; n_wd++; last_evt = cyc; end
        if (desc_valid && desc_ready) last_evt = cyc;
        if (in_valid && in_ready) n_in++;
        if (seg_done) begin n_done++; done_cyc = cyc; end
        if (seg_err) begin n_err++; err_cyc = cyc; end
    end

    // kind: 0 load, 1 refused, 2 skipped
    task automatic run_seg(input string req, input int kind, input int ty, input logic [2:0] fl,
                           input logic [31:0] pa, input logic [31:0] off, input int fs, input int ms,
                           input int seed);
        int a;
        int w;
        bit ex;
        bit fired;
        ex = fl[0];
        if (kind == 0) begin
            a = int'(pa % (1 << PB)) * 4;
            for (int i = 0; i < fs; i++) begin
                if (ex) exp_i[a % MEM] = pat(seed, i); else exp_d[a % MEM] = pat(seed, i);
                a++;
                if (ex && (i % 3 == 2)) begin exp_i[a % MEM] = 8'h00; a++; end
            end
            if (!ex) for (int i = fs; i < ms; i++) begin exp_d[a % MEM] = 8'h00; a++; end
        end
        n_wi = 0; n_wd = 0; n_in = 0; n_done = 0; n_err = 0;
        last_evt = -10; done_cyc = -1; err_cyc = -1;
        @(negedge clk); #1;
        while (!desc_ready) begin @(negedge clk); #1; end
        desc_type = 4'(ty); desc_flags = fl; desc_paddr = pa; desc_offset = off;
        desc_filesz = 32'(fs); desc_memsz = 32'(ms); desc_valid = 1'b1;
        @(negedge clk); #1;
        desc_valid = 1'b0;
        if (kind == 0) begin
            for (int i = 0; i < fs; i++) begin
                in_valid = 1'b1; in_data = pat(seed, i);
                w = 0;
                forever begin
                    fired = in_ready;
                    @(negedge clk); #1;
                    w++;
                    if (fired || w > 200) break;
                end
            end
            in_valid = 1'b0;
        end else begin
            in_valid = 1'b1; in_data = 8'h5A;
            repeat (4) @(negedge clk);
            #1 in_valid = 1'b0;
        end
        w = 0;
        while (kind != 2 && (n_done + n_err) == 0 && w < 500) begin @(negedge clk); #4; w++; end
        repeat (3) @(negedge clk);
        #4;
        a = 0;
        for (int j = 0; j < MEM; j++) a += int'(got_i[j] != exp_i[j]) + int'(got_d[j] != exp_d[j]);
        check(a == 0, req, "memory bytes differing", a, 0);
        check(n_in == (kind == 0 ? fs : 0), "R8", "stream bytes consumed", n_in, kind == 0 ? fs : 0);
        if (kind == 0) begin
            check(n_done == 1 && n_err == 0, "R7", "done pulses", n_done, 1);
            check(done_cyc == last_evt + 1, "R7", "done cycle", done_cyc, last_evt + 1);
            if (ex) begin
                check(n_wd == 0 && n_wi == fs + fs / 3, "R1", "instruction writes", n_wi, fs + fs / 3);
            end else begin
                check(n_wi == 0 && n_wd == (ms > fs ? ms : fs), "R1", "data writes", n_wd,
                      ms > fs ? ms : fs);
            end
        end else if (kind == 1) begin
            check(n_err == 1 && n_done == 0 && n_wi + n_wd == 0, "R6", "error pulses", n_err, 1);
            check(err_cyc == last_evt + 1, "R6", "error cycle", err_cyc, last_evt + 1);
        end else begin
            check(n_err + n_done + n_wi + n_wd == 0, "R5", "pulses plus writes", n_err + n_done + n_wi + n_wd, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int j = 0; j < MEM; j++) begin
            exp_i[j] = 8'hC5; exp_d[j] = 8'hC5; got_i[j] = 8'hC5; got_d[j] = 8'hC5;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #4;
        // R9 reset state
        check(desc_ready == 1'b1, "R9", "desc_ready after reset", int'(desc_ready), 1);
        check({in_ready, imem_we, dmem_we, seg_done, seg_err} == 5'b0, "R9", "outputs after reset",
              int'({in_ready, imem_we, dmem_we, seg_done, seg_err}), 0);
        // R3 instruction sweep over length, stall mode and high address bits (R2)
        for (int fs = 0; fs < 10; fs++) begin
            mode = fs % 3;
            run_seg("R3", 0, 1, 3'b001, 32'h0ABC_0000 | 32'(fs * 5), 32'(fs), fs, fs + 4, fs);
        end
        // R4 data sweep over file size and memory size
        for (int fs = 0; fs < 5; fs++) begin
            for (int ms = 0; ms < 7; ms++) begin
                mode = (fs + ms) % 3;
                run_seg("R4", 0, 1, 3'b000, 32'(40 + fs * 3 + ms), 32'd0, fs, ms, 20 + fs * 7 + ms);
            end
        end
        // R2 address wrap at the top of memory
        mode = 1;
        run_seg("R2", 0, 1, 3'b001, 32'h0000_FFFF, 32'd10, 6, 0, 77);
        run_seg("R2", 0, 1, 3'b010, 32'h0000_003F, 32'd10, 2, 9, 78);
        // R1 other flag bits ignored
        mode = 2;
        run_seg("R1", 0, 1, 3'b101, 32'd12, 32'd0, 5, 5, 90);
        run_seg("R1", 0, 1, 3'b110, 32'd12, 32'd0, 4, 6, 91);
        // R5 non-load types skipped
        run_seg("R5", 2, 2, 3'b001, 32'd20, 32'd0, 6, 6, 95);
        run_seg("R5", 2, 0, 3'b000, 32'd20, 32'd0, 6, 9, 96);
        // R6 bounds: one past the end refused, exact end accepted, wrap-around refused
        run_seg("R6", 1, 1, 3'b000, 32'd30, 32'd995, 6, 6, 97);
        run_seg("R6", 0, 1, 3'b000, 32'd30, 32'd994, 6, 6, 98);
        run_seg("R6", 1, 1, 3'b001, 32'd30, 32'hFFFF_FFF0, 32, 0, 99);
        // R8 stream resumes cleanly after skipped and refused descriptors
        mode = 0;
        run_seg("R8", 0, 1, 3'b001, 32'd50, 32'd0, 7, 0, 100);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule